// File: doc/BRIEF.md
# Flash ADC Thermometer-to-Binary Encoder

This block sits behind the comparator bank of a flash converter. It turns the 2^BITS-1 comparator decisions into a BITS-bit binary level. Input bit 0 carries the lowest-threshold comparator, T1. Input bit j-1 carries Tj. A clean word is a run of ones that starts at bit 0, with zeros above it. The level is the number of ones.

Each sample is captured in an input register together with its valid flag and a path select. It is encoded, and the result is caught in an output register, so every result appears two rising edges after its sample. The block offers two encoder paths:
- The bubble-tolerant path uses three-input transition detectors. They feed a wired-OR code table, so a stray comparator firing above the run is ignored.
- The Gray path maps each comparator to exactly one Gray bit. The Gray word is registered, and only then is it turned into binary. A single undecided comparator can therefore move the result by at most one Gray bit.

The parameter BITS ranges from 3 to 6.

Top module: `flash_therm_encoder`

## Requirements
- R1: While rst_n is low, and at the first edge after it, out_valid is 0 and out_code is 0.
- R2: out_valid equals the in_valid value sampled two rising clock edges earlier. A sample presented on consecutive cycles produces results on consecutive cycles, in order.
- R3: For a clean thermometer word of level L (bits 0..L-1 set, all others clear, L from 0 to 2^BITS-1), out_code equals L on both paths.
- R4: On the table path (sel_gray=0), detector row i (1 <= i <= 2^BITS-1) fires when T(i-1), T(i) and NOT T(i+1) all hold, with T0 taken as 1 and T(2^BITS) as 0. As a result, a stray set bit that has a clear bit directly below it does not change the output. For BITS=3, 7'b0010111 gives 3, 7'b0000101 gives 1 and 7'b0001011 gives 2.
- R5: When several table rows fire, out_code is the bitwise OR of their row numbers. For BITS=3, 7'b0001101 fires rows 1 and 4 and gives 5.
- R6: On the Gray path (sel_gray=1), Gray bit k is the OR, over m, of T((4m+1)*2^k) AND NOT T((4m+3)*2^k). The exception is the top bit, which equals T(2^(BITS-1)). Binary is then formed as b(top)=g(top) and b(k)=b(k+1) XOR g(k). For BITS=3: 7'b0010111 gives 2, 7'b0000101 gives 0, 7'b0001011 gives 5 and 7'b0001101 gives 7.
- R7: The path select is captured with its own sample. Alternating sel_gray on back-to-back samples gives each result from its own path.
- R8: A cycle with in_valid=0 captures nothing. out_code holds its last value while out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Comparator word is present this cycle |
| sel_gray | input | 1 | 0 selects the bubble-tolerant table path, 1 selects the Gray path |
| in_therm | input | 2^BITS-1 | Comparator outputs; bit 0 is the lowest threshold |
| out_valid | output | 1 | out_code carries a new result |
| out_code | output | BITS | Binary level |

## Verification
The bench feeds every clean level through both paths. A design that swapped the bit order or miscounted the level fails those checks outright.

It then aims at words that are not clean:
- An isolated stray one above the run must be dropped by the table path. A two-input detector would merge that stray one into a larger code.
- A broken run must fire two rows, and their codes must be ORed. An encoder that used priority would report only one of them.
- The same irregular words go through the Gray path, whose expected results depend on each comparator reaching exactly one Gray bit and on the XOR chain running from the top bit down.

Back-to-back samples with alternating path select and a gap catch three faults: an extra or missing pipeline stage, a path select that is not registered with its data, and an output that changes on an invalid cycle.

// File: rtl/flash_enc_pkg.sv
package flash_enc_pkg;

   // Path select encoding carried through the pipeline
   typedef enum logic {
      PATH_TABLE = 1'b0,
      PATH_GRAY  = 1'b1
   } enc_path_e;

   // Number of comparators for a BITS-bit flash converter
   function automatic int unsigned comp_count(input int unsigned bits);
      return (1 << bits) - 1;
   endfunction

endpackage

// File: rtl/fte_bubble_table.sv
// Bubble-tolerant transition detector feeding a wired-OR code table.
module fte_bubble_table #(
   parameter int unsigned BITS  = 3,
   parameter int unsigned NCOMP = 7
) (
   input  logic [NCOMP-1:0] therm,
   output logic [BITS-1:0]  code
);

   // ext[i] is T(i): T0 forced high, T(NCOMP+1) forced low
   logic [NCOMP+1:0] ext;
   logic [NCOMP:1]   row_hit;

   assign ext = {1'b0, therm, 1'b1};

   for (genvar i = 1; i <= NCOMP; i++) begin : g_row
      assign row_hit[i] = ext[i-1] & ext[i] & ~ext[i+1];
   end

   // Every firing row drives its own number onto the shared code lines
   always_comb begin
      code = '0;
      for (int i = 1; i <= NCOMP; i++) begin
         if (row_hit[i]) code = code | BITS'(i);
      end
   end

endmodule

// File: rtl/fte_therm_gray.sv
// Direct thermometer-to-Gray mapping: every comparator reaches one Gray bit.
module fte_therm_gray #(
   parameter int unsigned BITS  = 3,
   parameter int unsigned NCOMP = 7
) (
   input  logic [NCOMP-1:0] therm,
   output logic [BITS-1:0]  gray
);

   for (genvar k = 0; k < BITS; k++) begin : g_bit
      if (k == BITS - 1) begin : g_top
         // Top Gray bit is the midpoint comparator T(2^(BITS-1))
         assign gray[k] = therm[(1 << k) - 1];
      end else begin : g_low
         localparam int unsigned STEP  = 1 << k;
         localparam int unsigned TERMS = 1 << (BITS - k - 2);
         logic [TERMS-1:0] window;
         for (genvar m = 0; m < TERMS; m++) begin : g_win
            // Window opens at T((4m+1)*2^k) and closes at T((4m+3)*2^k)
            assign window[m] = therm[(4*m + 1)*STEP - 1]
                             & ~therm[(4*m + 3)*STEP - 1];
         end
         assign gray[k] = |window;
      end
   end

endmodule

// File: rtl/fte_gray2bin.sv
// Gray to binary conversion, rippling from the top bit downward.
module fte_gray2bin #(
   parameter int unsigned BITS = 3
) (
   input  logic [BITS-1:0] gray,
   output logic [BITS-1:0] bin
);

   assign bin[BITS-1] = gray[BITS-1];

   for (genvar k = BITS - 2; k >= 0; k--) begin : g_chain
      assign bin[k] = bin[k+1] ^ gray[k];
   end

endmodule

// File: rtl/flash_therm_encoder.sv
module flash_therm_encoder
   import flash_enc_pkg::*;
#(
   parameter int unsigned BITS  = 3,
   parameter int unsigned NCOMP = comp_count(BITS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             sel_gray,
   input  logic [NCOMP-1:0] in_therm,
   output logic             out_valid,
   output logic [BITS-1:0]  out_code
);

   // Elaboration-time parameter checks
   if (BITS < 3 || BITS > 6) begin : g_bad_bits
      $error("flash_therm_encoder: BITS must lie in 3..6");
   end
   if (NCOMP != comp_count(BITS)) begin : g_bad_ncomp
      $error("flash_therm_encoder: NCOMP must equal 2^BITS-1");
   end

   // Stage 1: comparator capture
   logic [NCOMP-1:0] therm_q;
   enc_path_e        path_q;
   logic             vld_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         therm_q <= '0;
         path_q  <= PATH_TABLE;
         vld_q   <= 1'b0;
      end else begin
         vld_q <= in_valid;
         if (in_valid) begin
            therm_q <= in_therm;
            path_q  <= enc_path_e'(sel_gray);
         end
      end
   end

   // Encoders
   logic [BITS-1:0] table_code;
   logic [BITS-1:0] gray_code;
   logic [BITS-1:0] stage_word;

   fte_bubble_table #(.BITS(BITS), .NCOMP(NCOMP)) u_table (
      .therm (therm_q),
      .code  (table_code)
   );

   fte_therm_gray #(.BITS(BITS), .NCOMP(NCOMP)) u_gray (
      .therm (therm_q),
      .gray  (gray_code)
   );

   assign stage_word = (path_q == PATH_GRAY) ? gray_code : table_code;

   // Stage 2: the Gray word is held before conversion, the table code as is
   logic [BITS-1:0] held_q;
   enc_path_e       held_path_q;
   logic            out_vld_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q      <= '0;
         held_path_q <= PATH_TABLE;
         out_vld_q   <= 1'b0;
      end else begin
         out_vld_q <= vld_q;
         if (vld_q) begin
            held_q      <= stage_word;
            held_path_q <= path_q;
         end
      end
   end

   logic [BITS-1:0] held_bin;

   fte_gray2bin #(.BITS(BITS)) u_g2b (
      .gray (held_q),
      .bin  (held_bin)
   );

   assign out_valid = out_vld_q;
   assign out_code  = (held_path_q == PATH_GRAY) ? held_bin : held_q;

endmodule

// File: rtl/flash_therm_encoder_chk.sv
module flash_therm_encoder_chk #(
   parameter int unsigned BITS  = 3,
   parameter int unsigned NCOMP = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [NCOMP-1:0] in_therm,
   input logic             out_valid,
   input logic [BITS-1:0]  out_code
);

   // Independent reference: clean words carry their level as a popcount
   logic            v1, v2;
   logic            clean1, clean2;
   logic [BITS-1:0] lvl1, lvl2;
   int unsigned     ones_now;
   logic            clean_now;

   always_comb begin
      ones_now  = $countones(in_therm);
      clean_now = ({1'b0, in_therm} == ((NCOMP+1)'(1) << ones_now) - (NCOMP+1)'(1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v1 <= 1'b0; v2 <= 1'b0;
         clean1 <= 1'b0; clean2 <= 1'b0;
         lvl1 <= '0; lvl2 <= '0;
      end else begin
         v1 <= in_valid;
         v2 <= v1;
         if (in_valid) begin
            clean1 <= clean_now;
            lvl1   <= BITS'(ones_now);
         end
         if (v1) begin
            clean2 <= clean1;
            lvl2   <= lvl1;
         end
      end
   end

   AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (!out_valid && out_code == '0)); // R1
   AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) out_valid == v2); // R2
   AST_CLEAN_LEVEL: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && clean2) |-> out_code == lvl2); // R3
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !out_valid |-> $stable(out_code)); // R8

endmodule

bind flash_therm_encoder flash_therm_encoder_chk #(.BITS(BITS), .NCOMP(NCOMP)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_therm  (in_therm),
   .out_valid (out_valid),
   .out_code  (out_code)
);

// File: tb/flash_therm_encoder_bench.sv
module flash_therm_encoder_bench;

   localparam int unsigned BITS  = 3;
   localparam int unsigned NCOMP = 7;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             in_valid = 1'b0;
   logic             sel_gray = 1'b0;
   logic [NCOMP-1:0] in_therm = '0;
   logic             out_valid;
   logic [BITS-1:0]  out_code;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #10 clk = ~clk;

   flash_therm_encoder #(.BITS(BITS)) u_flash_therm_encoder (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .sel_gray  (sel_gray),
      .in_therm  (in_therm),
      .out_valid (out_valid),
      .out_code  (out_code)
   );

   // Each entry holds {sel_gray, therm[6:0], expected[2:0]}
   localparam int NVEC = 10;
   localparam logic [10:0] VEC [NVEC] = '{
      {1'b0, 7'b0010111, 3'd3},   // R4 stray one dropped
      {1'b0, 7'b0000101, 3'd1},   // R4
      {1'b0, 7'b0001011, 3'd2},   // R4
      {1'b0, 7'b0001101, 3'd5},   // R5 rows 1 and 4 ORed
      {1'b0, 7'b1111111, 3'd7},   // R4 top row
      {1'b1, 7'b0010111, 3'd2},   // R6
      {1'b1, 7'b0000101, 3'd0},   // R6
      {1'b1, 7'b0001011, 3'd5},   // R6
      {1'b1, 7'b0001101, 3'd7},   // R6
      {1'b1, 7'b0001111, 3'd4}    // R6 midpoint bit
   };

   task automatic check(input string req, input logic [BITS-1:0] act_code,
                        input logic act_vld, input logic [BITS-1:0] exp_code,
                        input logic exp_vld);
      n_checks++;
      if (act_code !== exp_code || act_vld !== exp_vld) begin
         n_fail++;
         $display("FAIL %s: code=%0d valid=%0b expected code=%0d valid=%0b",
                  req, act_code, act_vld, exp_code, exp_vld);
      end
   endtask

   // Present one sample, wait through both registers, sample at the falling edge
   task automatic run_one(input logic path, input logic [NCOMP-1:0] t,
                          input string req, input logic [BITS-1:0] exp_code);
      @(negedge clk);
      in_valid = 1'b1; sel_gray = path; in_therm = t;
      @(negedge clk);
      in_valid = 1'b0;
      @(negedge clk);
      check(req, out_code, out_valid, exp_code, 1'b1);
   endtask

   initial begin
      #(20 * 20000);
      if (!done) begin
         n_fail++; n_checks++;
         $display("FAIL watchdog: code=%0d valid=%0b expected completion", out_code, out_valid);
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1 in reset", out_code, out_valid, '0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", out_code, out_valid, '0, 1'b0);

      // R3: every clean level on both paths
      for (int p = 0; p < 2; p++) begin
         for (int lv = 0; lv <= NCOMP; lv++) begin
            run_one(p[0], NCOMP'((1 << lv) - 1), "R3 clean level", BITS'(lv));
         end
      end

      // R4 R5 R6: irregular comparator words from the table
      for (int v = 0; v < NVEC; v++) begin
         run_one(VEC[v][10], VEC[v][9:3], "R4/R5/R6 vector", VEC[v][2:0]);
      end

      // R2 R7 R8: back-to-back samples with alternating path, then a gap
      @(negedge clk);
      in_valid = 1'b1; sel_gray = 1'b0; in_therm = 7'b0000011;   // level 2, table
      @(negedge clk);
      in_valid = 1'b1; sel_gray = 1'b1; in_therm = 7'b0011111;   // level 5, Gray
      @(negedge clk);
      in_valid = 1'b1; sel_gray = 1'b0; in_therm = 7'b0001101;   // table gives 5
      check("R2 first of stream", out_code, out_valid, 3'd2, 1'b1);
      @(negedge clk);
      in_valid = 1'b0; sel_gray = 1'b1; in_therm = 7'b0000001;   // ignored
      check("R7 second of stream on Gray path", out_code, out_valid, 3'd5, 1'b1);
      @(negedge clk);
      in_therm = 7'b1111111;
      check("R7 third of stream on table path", out_code, out_valid, 3'd5, 1'b1);
      @(negedge clk);
      check("R8 gap holds code", out_code, out_valid, 3'd5, 1'b0);
      @(negedge clk);
      check("R8 invalid word not captured", out_code, out_valid, 3'd5, 1'b0);
      in_valid = 1'b1; sel_gray = 1'b0;                           // in_therm still all ones
      @(negedge clk);
      in_valid = 1'b0;
      @(negedge clk);
      check("R2 valid after gap", out_code, out_valid, 3'd7, 1'b1);

      // R1: reset in mid-stream clears the outputs
      in_valid = 1'b1; sel_gray = 1'b1; in_therm = 7'b0000111;
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R1 mid-run reset", out_code, out_valid, '0, 1'b0);
      in_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 nothing leaks after reset", out_code, out_valid, '0, 1'b0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule